// File: doc/BRIEF.md
# CAN Transmit Mailbox Arbiter

This block decides which transmit mailbox a CAN protocol engine should send next. It holds a small state record for each mailbox: the arbitration identifier, a standard/extended flag, a local priority value, a direction bit that marks the mailbox as transmit or receive, and a pending flag. A policy input selects how candidates are ranked. The choices are smallest identifier, smallest mailbox number, or best local priority. Besides the winner, the block reports a status buffer. This is a free transmit mailbox when one exists, and otherwise the weakest pending candidate, so software knows where a new frame can go or which frame would be displaced.

A scanner state machine walks the mailboxes one per clock. Its states are `ST_IDLE`, `ST_SCAN` and `ST_DONE`. A mailbox change or a policy change in any state is the *restart* transition, which enters `ST_SCAN` at mailbox 0. `ST_SCAN` advances one index per cycle, and the *finish* transition after the last index moves to `ST_DONE`. There the results become valid and `scan_done` pulses. The *settle* transition then returns to `ST_IDLE`. When the engine accepts the offer, the mailbox is locked as granted and leaves arbitration. A release from the engine clears its pending flag.

Aborts clear a pending mailbox straight away. If the aborted mailbox is currently granted, the acknowledge waits for the engine's release.

Top module: `can_tx_arbiter`

## Requirements
- R1: After reset `win_valid`, `stat_valid`, `stat_empty`, `scan_done`, `gnt_busy` and `abort_ack` are all 0.
- R2: Only mailboxes whose direction bit is 1 (transmit), whose pending flag is 1 and which are not granted compete. A receive mailbox marked pending never wins.
- R3: With `pol_sel` = 2'b00 the candidate with the smallest 30-bit key wins. The key is {aligned identifier, extended flag}. An extended identifier is used as is. A standard identifier occupies key bits 29..19, with its 18 lower identifier bits zero. On equal identifiers a standard frame therefore beats an extended one.
- R4: With `pol_sel` = 2'b01 or 2'b11 the candidate with the smallest mailbox index wins.
- R5: With `pol_sel` = 2'b10 the candidate with the numerically smallest priority field wins (0 is most urgent).
- R6: Under every policy, equal keys resolve to the lower mailbox index.
- R7: The scan inspects one mailbox per cycle. `scan_done` pulses for one cycle exactly NUM_MB cycles after the cycle that carried a mailbox change. Any mailbox or policy change, including one during a scan, restarts the scan and invalidates the results until the next `scan_done`. After that the results hold until the next change.
- R8: If any transmit mailbox has pending 0, the status reports the lowest such index with `stat_empty` = 1. Otherwise it reports the weakest candidate under the current policy (largest key, equal keys to the higher index) with `stat_empty` = 0. If there is neither, `stat_valid` is 0.
- R9: `eng_start` while `win_valid` and no grant is held locks `win_idx` as `gnt_idx` with `gnt_busy` = 1. Configuration writes to the granted mailbox are ignored. `eng_finish` clears its pending flag and the grant.
- R10: An abort of a mailbox that is not granted clears its pending flag, and `abort_ack` pulses in the next cycle.
- R11: An abort of the granted mailbox raises no `abort_ack` until `eng_finish`. `abort_ack` pulses in the cycle after `eng_finish`, also when both arrive together. Further aborts are ignored while one waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pol_sel | input | 2 | Arbitration policy select |
| cfg_we | input | 1 | Write strobe for one mailbox record |
| cfg_idx | input | IDX_W | Mailbox written |
| cfg_id | input | 29 | Identifier (standard uses bits 10..0) |
| cfg_ext | input | 1 | 1 = extended identifier |
| cfg_prio | input | PRIO_W | Local priority value |
| cfg_tx | input | 1 | 1 = transmit mailbox |
| cfg_pend | input | 1 | Pending flag value |
| abort_req | input | 1 | Abort request strobe |
| abort_idx | input | IDX_W | Mailbox to abort |
| abort_ack | output | 1 | Abort completed pulse |
| eng_start | input | 1 | Engine accepts the offered mailbox |
| eng_finish | input | 1 | Engine releases the granted mailbox |
| win_valid | output | 1 | Winner result valid |
| win_idx | output | IDX_W | Winning mailbox index |
| gnt_busy | output | 1 | A mailbox is granted to the engine |
| gnt_idx | output | IDX_W | Granted mailbox index |
| stat_valid | output | 1 | Status buffer valid |
| stat_empty | output | 1 | 1 = status is a free mailbox, 0 = weakest pending |
| stat_idx | output | IDX_W | Status mailbox index |
| scan_done | output | 1 | One-cycle pulse at scan completion |

## Verification
Two pairs of events can land in the same cycle. The first is a mailbox write arriving while the scanner is part-way through the list. The bench injects a second write two cycles into a scan and judges the outcome by an unbroken completion latency of NUM_MB cycles, counted from the second write, and by a result that reflects both writes. The second is an abort of the granted mailbox coinciding with the engine's release. The bench raises both strobes in one cycle and expects the acknowledge one cycle later, with the grant gone and the mailbox out of arbitration.

// File: rtl/can_arb_pkg.sv
package can_arb_pkg;
    typedef enum logic [1:0] {
        POL_LOW_ID  = 2'b00,
        POL_LOW_BUF = 2'b01,
        POL_HI_PRIO = 2'b10,
        POL_SPARE   = 2'b11
    } policy_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_SCAN = 2'b01,
        ST_DONE = 2'b10
    } scan_state_e;

    localparam int ID_W  = 29;
    localparam int STD_W = 11;
    localparam int KEY_W = ID_W + 1;

    function automatic logic [KEY_W-1:0] rank_key(
        input policy_e pol, input logic [ID_W-1:0] id,
        input logic ext, input logic [KEY_W-1:0] prio);
        logic [ID_W-1:0] aligned;
        aligned = ext ? id : {id[STD_W-1:0], {(ID_W-STD_W){1'b0}}};
        unique case (pol)
            POL_LOW_ID:  rank_key = {aligned, ext};
            POL_HI_PRIO: rank_key = prio;
            default:     rank_key = '0;
        endcase
    endfunction
endpackage

// File: rtl/can_mb_store.sv
module can_mb_store #(
    parameter int NUM_MB = 8,
    parameter int PRIO_W = 3,
    parameter int IDX_W  = $clog2(NUM_MB)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [IDX_W-1:0]              cfg_idx,
    input  logic [28:0]                   cfg_id,
    input  logic                          cfg_ext,
    input  logic [PRIO_W-1:0]             cfg_prio,
    input  logic                          cfg_tx,
    input  logic                          cfg_pend,
    input  logic                          abort_req,
    input  logic [IDX_W-1:0]              abort_idx,
    input  logic                          eng_start,
    input  logic                          eng_finish,
    input  logic                          offer_valid,
    input  logic [IDX_W-1:0]              offer_idx,
    output logic [NUM_MB-1:0]             mb_tx,
    output logic [NUM_MB-1:0]             mb_pend,
    output logic [NUM_MB-1:0]             mb_ext,
    output logic [NUM_MB-1:0][28:0]       mb_id,
    output logic [NUM_MB-1:0][PRIO_W-1:0] mb_prio,
    output logic                          gnt_busy,
    output logic [IDX_W-1:0]              gnt_idx,
    output logic                          abort_ack,
    output logic                          chg
);
    logic             ab_wait;
    logic [IDX_W-1:0] ab_idx_q;
    logic cfg_ok, take, fin, ab_hit_gnt, ab_free;

    always_comb begin
        cfg_ok     = cfg_we && !(gnt_busy && cfg_idx == gnt_idx);
        take       = eng_start && offer_valid && !gnt_busy;
        fin        = eng_finish && gnt_busy;
        ab_hit_gnt = abort_req && !ab_wait && gnt_busy && abort_idx == gnt_idx;
        ab_free    = abort_req && !ab_wait && !ab_hit_gnt;
        chg        = cfg_ok || take || fin || (ab_free && mb_pend[abort_idx]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mb_tx <= '0; mb_pend <= '0; mb_ext <= '0; mb_id <= '0; mb_prio <= '0;
            gnt_busy <= 1'b0; gnt_idx <= '0;
            ab_wait <= 1'b0; ab_idx_q <= '0; abort_ack <= 1'b0;
        end else begin
            abort_ack <= 1'b0;
            if (cfg_ok) begin
                mb_tx[cfg_idx]   <= cfg_tx;
                mb_pend[cfg_idx] <= cfg_pend;
                mb_ext[cfg_idx]  <= cfg_ext;
                mb_id[cfg_idx]   <= cfg_id;
                mb_prio[cfg_idx] <= cfg_prio;
            end
            if (take) begin
                gnt_busy <= 1'b1;
                gnt_idx  <= offer_idx;
            end
            if (fin) begin
                mb_pend[gnt_idx] <= 1'b0;
                gnt_busy         <= 1'b0;
                if (ab_wait || ab_hit_gnt) begin
                    abort_ack <= 1'b1;
                    ab_wait   <= 1'b0;
                end
            end else if (ab_hit_gnt) begin
                ab_wait <= 1'b1;
            end
            if (ab_hit_gnt) ab_idx_q <= abort_idx;
            if (ab_free) begin
                mb_pend[abort_idx] <= 1'b0;
                abort_ack          <= 1'b1;
                ab_idx_q           <= abort_idx;
            end
        end
    end

    // R9
    gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_busy && !eng_finish) |=> (gnt_busy && gnt_idx == $past(gnt_idx)));
    // R10
    abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_ack |-> !mb_pend[ab_idx_q]);
    // R11
    abort_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_wait && !eng_finish) |=> !abort_ack);
endmodule

// File: rtl/can_tx_scan.sv
module can_tx_scan
    import can_arb_pkg::*;
#(
    parameter int NUM_MB = 8,
    parameter int PRIO_W = 3,
    parameter int IDX_W  = $clog2(NUM_MB)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    mode,
    input  logic                          chg,
    input  logic [NUM_MB-1:0]             mb_tx,
    input  logic [NUM_MB-1:0]             mb_pend,
    input  logic [NUM_MB-1:0]             mb_ext,
    input  logic [NUM_MB-1:0][28:0]       mb_id,
    input  logic [NUM_MB-1:0][PRIO_W-1:0] mb_prio,
    input  logic                          gnt_busy,
    input  logic [IDX_W-1:0]              gnt_idx,
    output logic                          offer_valid,
    output logic [IDX_W-1:0]              win_idx,
    output logic                          stat_valid,
    output logic                          stat_empty,
    output logic [IDX_W-1:0]              stat_idx,
    output logic                          scan_done
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_MB - 1);

    scan_state_e      state;
    logic [IDX_W-1:0] idx, bidx, widx, eidx;
    logic [KEY_W-1:0] bkey, wkey, cur_key;
    logic             bf, wf, ef, res_ok;
    logic [1:0]       mode_q;
    logic             restart, cur_cand, cur_empty, better, weaker;

    always_comb begin
        restart   = chg || (mode != mode_q);
        cur_cand  = mb_tx[idx] && mb_pend[idx] && !(gnt_busy && gnt_idx == idx);
        cur_empty = mb_tx[idx] && !mb_pend[idx];
        cur_key   = rank_key(policy_e'(mode), mb_id[idx], mb_ext[idx], KEY_W'(mb_prio[idx]));
        better    = cur_cand && (!bf || cur_key < bkey);
        weaker    = cur_cand && (!wf || cur_key >= wkey);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; idx <= '0; res_ok <= 1'b1; mode_q <= 2'b00;
            bf <= 1'b0; wf <= 1'b0; ef <= 1'b0;
            bidx <= '0; widx <= '0; eidx <= '0; bkey <= '0; wkey <= '0;
        end else begin
            mode_q <= mode;
            if (restart) begin
                state <= ST_SCAN; idx <= '0; res_ok <= 1'b0;
                bf <= 1'b0; wf <= 1'b0; ef <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_SCAN: begin
                        if (better) begin bf <= 1'b1; bidx <= idx; bkey <= cur_key; end
                        if (weaker) begin wf <= 1'b1; widx <= idx; wkey <= cur_key; end
                        if (cur_empty && !ef) begin ef <= 1'b1; eidx <= idx; end
                        if (idx == LAST) begin
                            state  <= ST_DONE;
                            res_ok <= 1'b1;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                    ST_DONE: state <= ST_IDLE;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        offer_valid = res_ok && bf;
        win_idx     = bidx;
        stat_valid  = res_ok && (ef || wf);
        stat_empty  = res_ok && ef;
        stat_idx    = ef ? eidx : widx;
        scan_done   = (state == ST_DONE);
    end

    // R7
    scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && !restart && idx != LAST) |=> (idx == IDX_W'($past(idx) + 1'b1)));
    // R7
    restart_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!offer_valid && !stat_valid && !scan_done));
endmodule

// File: rtl/can_tx_arbiter.sv
module can_tx_arbiter #(
    parameter int NUM_MB = 8,
    parameter int PRIO_W = 3,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        pol_sel,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [28:0]       cfg_id,
    input  logic              cfg_ext,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic              cfg_tx,
    input  logic              cfg_pend,
    input  logic              abort_req,
    input  logic [IDX_W-1:0]  abort_idx,
    output logic              abort_ack,
    input  logic              eng_start,
    input  logic              eng_finish,
    output logic              win_valid,
    output logic [IDX_W-1:0]  win_idx,
    output logic              gnt_busy,
    output logic [IDX_W-1:0]  gnt_idx,
    output logic              stat_valid,
    output logic              stat_empty,
    output logic [IDX_W-1:0]  stat_idx,
    output logic              scan_done
);
    logic [NUM_MB-1:0]             mb_tx, mb_pend, mb_ext;
    logic [NUM_MB-1:0][28:0]       mb_id;
    logic [NUM_MB-1:0][PRIO_W-1:0] mb_prio;
    logic                          chg;

    can_mb_store #(.NUM_MB(NUM_MB), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_store (
        .clk, .rst_n, .cfg_we, .cfg_idx, .cfg_id, .cfg_ext, .cfg_prio, .cfg_tx, .cfg_pend,
        .abort_req, .abort_idx, .eng_start, .eng_finish,
        .offer_valid(win_valid), .offer_idx(win_idx),
        .mb_tx, .mb_pend, .mb_ext, .mb_id, .mb_prio,
        .gnt_busy, .gnt_idx, .abort_ack, .chg);

    can_tx_scan #(.NUM_MB(NUM_MB), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_scan (
        .clk, .rst_n, .mode(pol_sel), .chg,
        .mb_tx, .mb_pend, .mb_ext, .mb_id, .mb_prio, .gnt_busy, .gnt_idx,
        .offer_valid(win_valid), .win_idx, .stat_valid, .stat_empty, .stat_idx, .scan_done);

    // R2
    win_is_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (mb_tx[win_idx] && mb_pend[win_idx] && !(gnt_busy && gnt_idx == win_idx)));
    // R8
    stat_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_empty |-> (mb_tx[stat_idx] && !mb_pend[stat_idx]));
endmodule

// File: tb/can_tx_arbiter_test.sv
module can_tx_arbiter_test;
    localparam int N = 8;
    localparam int PW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] pol = 2'b00;
    logic cfg_we = 0, cfg_ext = 0, cfg_tx = 0, cfg_pend = 0;
    logic [2:0] cfg_idx = '0, abort_idx = '0;
    logic [28:0] cfg_id = '0;
    logic [PW-1:0] cfg_prio = '0;
    logic abort_req = 0, eng_start = 0, eng_finish = 0;
    logic abort_ack, win_valid, gnt_busy, stat_valid, stat_empty, scan_done;
    logic [2:0] win_idx, gnt_idx, stat_idx;

    int checks = 0, errors = 0;
    bit m_tx[N], m_pend[N], m_ext[N];
    logic [28:0] m_id[N];
    int m_prio[N];
    bit m_gbusy = 0;
    int m_gidx = 0;
    bit e_wv, e_sv, e_se;
    int e_wi, e_si;

    always #10 clk = ~clk;

    can_tx_arbiter #(.NUM_MB(N), .PRIO_W(PW)) uut (
        .clk, .rst_n, .pol_sel(pol), .cfg_we, .cfg_idx, .cfg_id, .cfg_ext, .cfg_prio,
        .cfg_tx, .cfg_pend, .abort_req, .abort_idx, .abort_ack, .eng_start, .eng_finish,
        .win_valid, .win_idx, .gnt_busy, .gnt_idx, .stat_valid, .stat_empty, .stat_idx,
        .scan_done);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [29:0] bkey(int i);
        logic [28:0] al;
        al = m_ext[i] ? m_id[i] : {m_id[i][10:0], 18'd0};
        if (pol == 2'b00) return {al, m_ext[i]};
        if (pol == 2'b10) return 30'(m_prio[i]);
        return 30'd0;
    endfunction

    task automatic model();
        logic [29:0] bk, wk, k;
        bit wf, ef, c;
        e_wv = 0; wf = 0; ef = 0; e_wi = 0; e_si = 0; bk = '0; wk = '0;
        for (int i = 0; i < N; i++) begin
            c = m_tx[i] && m_pend[i] && !(m_gbusy && m_gidx == i);
            k = bkey(i);
            if (c && (!e_wv || k < bk)) begin e_wv = 1; e_wi = i; bk = k; end
            if (c && (!wf || k >= wk)) begin wf = 1; wk = k; if (!ef) e_si = i; end
            if (m_tx[i] && !m_pend[i] && !ef) begin ef = 1; e_si = i; end
        end
        e_sv = ef || wf;
        e_se = ef;
    endtask

    task automatic check_all(input string req);
        model();
        chk({req, " win_valid"}, int'(win_valid), int'(e_wv));
        if (e_wv) chk({req, " win_idx"}, int'(win_idx), e_wi);
        chk({req, " stat_valid"}, int'(stat_valid), int'(e_sv));
        chk({req, " stat_empty"}, int'(stat_empty), int'(e_se));
        if (e_sv) chk({req, " stat_idx"}, int'(stat_idx), e_si);
    endtask

    task automatic wait_done(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!scan_done && n < 100);
    endtask

    task automatic wr(input int i, input bit tx, input bit pd, input bit ex,
                      input logic [28:0] id, input int pr);
        cfg_we = 1; cfg_idx = 3'(i); cfg_tx = tx; cfg_pend = pd; cfg_ext = ex;
        cfg_id = id; cfg_prio = PW'(pr);
        @(negedge clk);
        cfg_we = 0;
        if (!(m_gbusy && m_gidx == i)) begin
            m_tx[i] = tx; m_pend[i] = pd; m_ext[i] = ex; m_id[i] = id; m_prio[i] = pr;
        end
    endtask

    task automatic wr_wait(input string req, input int i, input bit tx, input bit pd,
                           input bit ex, input logic [28:0] id, input int pr);
        int n;
        wr(i, tx, pd, ex, id, pr);
        wait_done(n);
        chk({req, " R7 latency"}, n, N);
        check_all(req);
    endtask

    task automatic set_pol(input logic [1:0] p, input string req);
        int n;
        pol = p;
        @(negedge clk);
        wait_done(n);
        check_all(req);
    endtask

    task automatic grant();
        int n;
        model();
        eng_start = 1;
        @(negedge clk);
        eng_start = 0;
        chk("R9 gnt_busy", int'(gnt_busy), 1);
        chk("R9 gnt_idx", int'(gnt_idx), e_wi);
        m_gbusy = 1; m_gidx = e_wi;
        wait_done(n);
        check_all("R9 granted excluded");
    endtask

    initial begin
        int n;
        void'($urandom(32'd1234));
        for (int i = 0; i < N; i++) begin
            m_tx[i] = 0; m_pend[i] = 0; m_ext[i] = 0; m_id[i] = '0; m_prio[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 win_valid", int'(win_valid), 0);
        chk("R1 stat_valid", int'(stat_valid), 0);
        chk("R1 scan_done", int'(scan_done), 0);
        chk("R1 gnt_busy", int'(gnt_busy), 0);
        chk("R1 abort_ack", int'(abort_ack), 0);

        // R3: aligned standard 0x001 vs extended 0x3FFFF -> extended smaller
        wr_wait("R3", 3, 1, 1, 0, 29'h001, 4);
        wr_wait("R3 ext smaller", 5, 1, 1, 1, 29'h0003FFFF, 4);
        chk("R3 ext wins", int'(win_idx), 5);
        // R3: equal identifier, standard beats extended at lower index
        wr_wait("R3 tie", 1, 1, 1, 1, 29'h00040000, 6);
        chk("R3 std beats ext", int'(win_idx), 5);
        wr_wait("R3 remove", 5, 1, 1, 1, 29'h1FFFFFFF, 3);
        chk("R3 std over equal ext", int'(win_idx), 3);
        // R4
        set_pol(2'b01, "R4 mode01");
        chk("R4 lowest buffer", int'(win_idx), 1);
        set_pol(2'b11, "R4 mode11");
        chk("R4 spare code", int'(win_idx), 1);
        // R5, R6
        set_pol(2'b10, "R5");
        wr_wait("R6 prio tie", 5, 1, 1, 1, 29'h1FFFFFFF, 4);
        chk("R6 tie lower index", int'(win_idx), 3);
        chk("R8 weakest", int'(stat_idx), 1);
        wr_wait("R5 best prio", 5, 1, 1, 1, 29'h1FFFFFFF, 0);
        chk("R5 smallest prio", int'(win_idx), 5);
        // R8 empty buffer
        wr_wait("R8 empty", 6, 1, 0, 0, 29'h0, 0);
        chk("R8 stat_empty", int'(stat_empty), 1);
        // R2 receive mailbox never wins
        wr_wait("R2 rx", 2, 0, 1, 0, 29'h0, 0);
        chk("R2 rx ignored", int'(win_idx), 5);

        // R7 write landing mid-scan restarts
        wr(0, 1, 1, 0, 29'h0, 7);
        repeat (2) @(negedge clk);
        wr(7, 1, 1, 0, 29'h0, 0);
        wait_done(n);
        chk("R7 restart latency", n, N);
        check_all("R7 midscan");

        // R9 grant, ignored write, release
        grant();
        n = int'(gnt_idx);
        wr(n, 0, 0, 0, 29'h0, 0);
        repeat (3) begin
            @(negedge clk);
            chk("R9 write to granted ignored", int'(scan_done), 0);
        end
        check_all("R9 still valid");
        eng_finish = 1;
        @(negedge clk);
        eng_finish = 0;
        m_pend[m_gidx] = 0; m_gbusy = 0;
        chk("R9 released", int'(gnt_busy), 0);
        wait_done(n);
        check_all("R9 after finish");

        // R10 abort non-granted pending mailbox
        model();
        n = e_wi;
        abort_req = 1; abort_idx = 3'(n);
        @(negedge clk);
        abort_req = 0;
        chk("R10 abort_ack", int'(abort_ack), 1);
        m_pend[n] = 0;
        wait_done(n);
        check_all("R10 removed");

        // R11 abort of granted mailbox waits for release
        grant();
        abort_req = 1; abort_idx = gnt_idx;
        @(negedge clk);
        abort_req = 0;
        chk("R11 no early ack", int'(abort_ack), 0);
        @(negedge clk);
        chk("R11 no ack while held", int'(abort_ack), 0);
        chk("R11 grant held", int'(gnt_busy), 1);
        eng_finish = 1;
        @(negedge clk);
        eng_finish = 0;
        chk("R11 ack after release", int'(abort_ack), 1);
        m_pend[m_gidx] = 0; m_gbusy = 0;
        wait_done(n);
        check_all("R11 after abort");

        // R11 abort and release in the same cycle
        grant();
        abort_req = 1; abort_idx = gnt_idx; eng_finish = 1;
        @(negedge clk);
        abort_req = 0; eng_finish = 0;
        chk("R11 same-cycle ack", int'(abort_ack), 1);
        chk("R11 same-cycle release", int'(gnt_busy), 0);
        m_pend[m_gidx] = 0; m_gbusy = 0;
        wait_done(n);
        check_all("R11 same-cycle result");

        // Random mixture, R3 R4 R5 R6 R8
        for (int it = 0; it < 80; it++) begin
            logic [28:0] rid;
            bit ex;
            if (it % 10 == 0) set_pol(2'($urandom % 4), "R6 random mode");
            ex = ($urandom % 2) == 1;
            rid = 29'($urandom % 4);
            if (ex && ($urandom % 3 == 0)) rid = rid << 18;
            wr_wait("R6 random", int'($urandom % N), ($urandom % 4) != 0,
                    ($urandom % 10) < 7, ex, rid, int'($urandom % 3));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule